// File: doc/BRIEF.md
# EPROM Pulse-and-Verify Programming Sequencer

This block writes bytes into a UV-erasable, byte-wide EPROM one location at a time. A host gives it a 13-bit byte address, the data and a start command. The block then drives the memory's enable and strobe lines, the address bus and a tristated data bus, and it reads the memory's stored byte back over the same bus. It runs an adaptive algorithm. The block gives a 1 ms programming pulse and reads the byte back after each one. It repeats this until the byte matches, up to a retry limit. It then gives one long closing pulse whose length scales with the number of short pulses that were used.

Before any pulse, the sequencer reads the location and refuses the request if the new byte would need any stored 0 to become 1. Erasure is the only way to get a 1 back, so such a request cannot succeed. The short pulses, the read-backs and the closing pulse run with the supply-select flag set to the elevated setting. The last read-back runs with the flag at the nominal setting. A word mode writes a 16-bit value as two bytes, high byte first. Millisecond timing comes from the system clock through a prescaler parameter, so simulation can use a short tick.

Top module: `eprom_burner`

## Requirements
- R1: After reset the block is idle. The outputs are: busy_o=0, done_o=0, ce_n_o=1, oe_n_o=1, pgm_n_o=1, mdq_oe_o=0, hv_sel_o=0.
- R2: On start, the target byte is read first (oe_n_o low, bus released). The request ends with reject_o=1 and prime_cnt_o=0, with no strobe and no change to memory, if (~stored & wanted) is non-zero for any target byte. In word mode both bytes are checked before any pulse.
- R3: Each short pulse holds pgm_n_o low for exactly TICK_DIV clocks (1 ms). During it ce_n_o=0, oe_n_o=1, mdq_oe_o=1 and hv_sel_o=1. Address and data are driven for at least one clock before the strobe falls.
- R4: After each short pulse the byte is read back with oe_n_o=0, pgm_n_o=1 and mdq_oe_o=0. The data driver is released for at least one clock before oe_n_o falls, and it is never on while oe_n_o is low.
- R5: A read-back mismatch gives another short pulse. If the byte still mismatches after MAX_PRIME (15) short pulses, the request ends with fail_o=1, prime_cnt_o=15 and no closing pulse.
- R6: On the first read-back match after n short pulses, a closing pulse follows with pgm_n_o low for FINAL_MULT×n ms (4×n×TICK_DIV clocks). prime_cnt_o then shows n.
- R7: After the closing pulse, the byte is read once more with hv_sel_o=0. A match ends the byte with pass_o=1. Every request ends with exactly one of pass_o, fail_o or reject_o set.
- R8: With word_i=1 the high byte wdata_i[15:8] goes first, to address {addr_i[12:1],0}. The low byte wdata_i[7:0] goes next, to {addr_i[12:1],1}. prime_cnt_o reports the byte handled last. With word_i=0, wdata_i[7:0] goes to addr_i.
- R9: busy_o rises the clock after an accepted start and stays high until done_o. done_o is a one-clock pulse with busy_o low. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only when idle |
| word_i | input | 1 | 1 = write 16-bit word as two bytes |
| addr_i | input | ADDR_W (13) | Target byte address |
| wdata_i | input | 2×BYTE_W (16) | Data; low byte used in byte mode |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-clock completion pulse |
| pass_o | output | 1 | Last request succeeded |
| fail_o | output | 1 | Last request hit a verify failure |
| reject_o | output | 1 | Last request needed a 0-to-1 change |
| prime_cnt_o | output | 4 | Short pulses used on the last byte |
| hv_sel_o | output | 1 | 1 = elevated programming supply |
| ce_n_o | output | 1 | Memory chip enable, active low |
| oe_n_o | output | 1 | Memory output enable, active low |
| pgm_n_o | output | 1 | Program strobe, active low |
| maddr_o | output | ADDR_W (13) | Memory byte address |
| mdq_o | output | BYTE_W (8) | Data driven toward the memory |
| mdq_oe_o | output | 1 | Data bus driver enable |
| mdq_i | input | BYTE_W (8) | Data read from the memory |

## Verification
The assertions assume that reset is held at the first clock edge. They also assume that the memory's returned byte, sampled at the end of a two-clock read, is settled by then. The memory model in the bench updates its read value on the falling clock edge, which keeps that timing. The protocol assertions do not depend on what the memory returns. The bench model programs a byte only at the end of a strobe that shows the right bus levels. Each location needs a chosen number of strobes before its bits take effect, so the retry counts in the stimulus stay between 1 and 16.

// File: rtl/epb_pkg.sv
package epb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHK_A,
        ST_CHK_B,
        ST_SETUP,
        ST_PRIME,
        ST_GAP,
        ST_VER_A,
        ST_VER_B,
        ST_FSETUP,
        ST_FINAL,
        ST_GAP2,
        ST_NOM_A,
        ST_NOM_B,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic pgm_n;
        logic dq_oe;
        logic hv;
    } mem_ctl_t;

    typedef struct packed {
        logic pass;
        logic fail;
        logic reject;
    } outcome_t;

    function automatic mem_ctl_t ctl_for(seq_state_e s);
        mem_ctl_t c;
        c = '{ce_n: 1'b0, oe_n: 1'b1, pgm_n: 1'b1, dq_oe: 1'b0, hv: 1'b0};
        case (s)
            ST_IDLE, ST_DONE:   c.ce_n = 1'b1;
            ST_CHK_A, ST_CHK_B: c.oe_n = 1'b0;
            ST_SETUP, ST_FSETUP: begin
                c.dq_oe = 1'b1;
                c.hv    = 1'b1;
            end
            ST_PRIME, ST_FINAL: begin
                c.dq_oe = 1'b1;
                c.pgm_n = 1'b0;
                c.hv    = 1'b1;
            end
            ST_GAP, ST_GAP2:    c.hv = 1'b1;
            ST_VER_A, ST_VER_B: begin
                c.oe_n = 1'b0;
                c.hv   = 1'b1;
            end
            ST_NOM_A, ST_NOM_B: c.oe_n = 1'b0;
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/epb_ms_timer.sv
module epb_ms_timer #(
    parameter int TICK_DIV = 50000,
    parameter int MS_W     = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            run,
    input  logic [MS_W-1:0] ms_len,
    output logic            expire
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [PW-1:0]   presc_q;
    logic [MS_W-1:0] rem_q;
    logic            wrap;

    assign wrap = (presc_q == PW'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
            rem_q   <= '0;
        end else if (load) begin
            presc_q <= '0;
            rem_q   <= ms_len;
        end else if (run) begin
            if (wrap) begin
                presc_q <= '0;
                rem_q   <= rem_q - 1'b1;
            end else begin
                presc_q <= presc_q + 1'b1;
            end
        end
    end

    // last prescaler cycle of the last millisecond
    assign expire = run && wrap && (rem_q == MS_W'(1));

endmodule

// File: rtl/epb_byte_cmp.sv
module epb_byte_cmp #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] stored,
    input  logic [BYTE_W-1:0] wanted,
    output logic              match,
    output logic              needs_erase
);
    assign match       = (stored == wanted);
    // a bit wanted as 1 that is already 0 cannot be reached by programming
    assign needs_erase = |(~stored & wanted);
endmodule

// File: rtl/eprom_burner.sv
module eprom_burner
    import epb_pkg::*;
#(
    parameter int TICK_DIV   = 50000,
    parameter int MAX_PRIME  = 15,
    parameter int FINAL_MULT = 4,
    parameter int ADDR_W     = 13,
    parameter int BYTE_W     = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start_i,
    input  logic                           word_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [2*BYTE_W-1:0]            wdata_i,
    output logic                           busy_o,
    output logic                           done_o,
    output logic                           pass_o,
    output logic                           fail_o,
    output logic                           reject_o,
    output logic [$clog2(MAX_PRIME+1)-1:0] prime_cnt_o,
    output logic                           hv_sel_o,
    output logic                           ce_n_o,
    output logic                           oe_n_o,
    output logic                           pgm_n_o,
    output logic [ADDR_W-1:0]              maddr_o,
    output logic [BYTE_W-1:0]              mdq_o,
    output logic                           mdq_oe_o,
    input  logic [BYTE_W-1:0]              mdq_i
);
    localparam int CW   = $clog2(MAX_PRIME + 1);
    localparam int MS_W = $clog2(FINAL_MULT * MAX_PRIME + 1);
    localparam logic [MS_W-1:0] MULT_V = MS_W'(FINAL_MULT);

    seq_state_e            st_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [2*BYTE_W-1:0]   wdata_q;
    logic                  word_q;
    logic                  lo_sel_q;
    logic [CW-1:0]         cnt_q;
    outcome_t              out_q;

    logic [ADDR_W-1:0]     cur_addr;
    logic [BYTE_W-1:0]     cur_data;
    logic                  rd_match, rd_erase;
    logic                  tmr_load, tmr_run, tmr_exp;
    logic [MS_W-1:0]       tmr_ms;
    mem_ctl_t              ctl;

    // byte currently addressed: high byte (even address) first in word mode
    always_comb begin
        if (word_q) begin
            cur_addr = {addr_q[ADDR_W-1:1], lo_sel_q};
            cur_data = lo_sel_q ? wdata_q[BYTE_W-1:0] : wdata_q[2*BYTE_W-1:BYTE_W];
        end else begin
            cur_addr = addr_q;
            cur_data = wdata_q[BYTE_W-1:0];
        end
    end

    epb_byte_cmp #(.BYTE_W(BYTE_W)) cmp_i (
        .stored      (mdq_i),
        .wanted      (cur_data),
        .match       (rd_match),
        .needs_erase (rd_erase)
    );

    assign tmr_load = (st_q == ST_SETUP) || (st_q == ST_FSETUP);
    assign tmr_run  = (st_q == ST_PRIME) || (st_q == ST_FINAL);
    assign tmr_ms   = (st_q == ST_FSETUP) ? MULT_V * MS_W'(cnt_q) : MS_W'(1);

    epb_ms_timer #(.TICK_DIV(TICK_DIV), .MS_W(MS_W)) tmr_i (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .run    (tmr_run),
        .ms_len (tmr_ms),
        .expire (tmr_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            addr_q   <= '0;
            wdata_q  <= '0;
            word_q   <= 1'b0;
            lo_sel_q <= 1'b0;
            cnt_q    <= '0;
            out_q    <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start_i) begin
                    addr_q   <= addr_i;
                    wdata_q  <= wdata_i;
                    word_q   <= word_i;
                    lo_sel_q <= 1'b0;
                    cnt_q    <= '0;
                    out_q    <= '0;
                    st_q     <= ST_CHK_A;
                end
                ST_CHK_A: st_q <= ST_CHK_B;
                ST_CHK_B: begin
                    if (rd_erase) begin
                        out_q.reject <= 1'b1;
                        st_q         <= ST_DONE;
                    end else if (word_q && !lo_sel_q) begin
                        lo_sel_q <= 1'b1;
                        st_q     <= ST_CHK_A;
                    end else begin
                        lo_sel_q <= 1'b0;
                        st_q     <= ST_SETUP;
                    end
                end
                ST_SETUP: st_q <= ST_PRIME;
                ST_PRIME: if (tmr_exp) begin
                    cnt_q <= cnt_q + 1'b1;
                    st_q  <= ST_GAP;
                end
                ST_GAP:   st_q <= ST_VER_A;
                ST_VER_A: st_q <= ST_VER_B;
                ST_VER_B: begin
                    if (rd_match) begin
                        st_q <= ST_FSETUP;
                    end else if (cnt_q == CW'(MAX_PRIME)) begin
                        out_q.fail <= 1'b1;
                        st_q       <= ST_DONE;
                    end else begin
                        st_q <= ST_SETUP;
                    end
                end
                ST_FSETUP: st_q <= ST_FINAL;
                ST_FINAL:  if (tmr_exp) st_q <= ST_GAP2;
                ST_GAP2:   st_q <= ST_NOM_A;
                ST_NOM_A:  st_q <= ST_NOM_B;
                ST_NOM_B: begin
                    if (!rd_match) begin
                        out_q.fail <= 1'b1;
                        st_q       <= ST_DONE;
                    end else if (word_q && !lo_sel_q) begin
                        lo_sel_q <= 1'b1;
                        cnt_q    <= '0;
                        st_q     <= ST_SETUP;
                    end else begin
                        out_q.pass <= 1'b1;
                        st_q       <= ST_DONE;
                    end
                end
                ST_DONE:  st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    assign ctl         = ctl_for(st_q);
    assign ce_n_o      = ctl.ce_n;
    assign oe_n_o      = ctl.oe_n;
    assign pgm_n_o     = ctl.pgm_n;
    assign mdq_oe_o    = ctl.dq_oe;
    assign hv_sel_o    = ctl.hv;
    assign maddr_o     = cur_addr;
    assign mdq_o       = cur_data;
    assign busy_o      = (st_q != ST_IDLE) && (st_q != ST_DONE);
    assign done_o      = (st_q == ST_DONE);
    assign pass_o      = out_q.pass;
    assign fail_o      = out_q.fail;
    assign reject_o    = out_q.reject;
    assign prime_cnt_o = cnt_q;

endmodule

// File: rtl/epb_checker.sv
module epb_checker #(
    parameter int MAX_PRIME = 15,
    parameter int ADDR_W    = 13
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           busy,
    input logic                           done,
    input logic                           pass,
    input logic                           fail,
    input logic                           reject,
    input logic [$clog2(MAX_PRIME+1)-1:0] prime_cnt,
    input logic                           hv,
    input logic                           ce_n,
    input logic                           oe_n,
    input logic                           pgm_n,
    input logic [ADDR_W-1:0]              maddr,
    input logic                           dq_oe
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy) |-> (ce_n && oe_n && pgm_n && !dq_oe)); // R1

    AST_REJECT_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (done && reject) |-> (prime_cnt == '0)); // R2

    AST_STROBE_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(pgm_n) |-> ($past(dq_oe) && $stable(maddr))); // R3

    AST_STROBE_LEVELS: assert property (@(posedge clk) disable iff (rst)
        (!pgm_n) |-> (!ce_n && oe_n && dq_oe && hv)); // R3

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        (!oe_n) |-> (!dq_oe && pgm_n)); // R4

    AST_BUS_TURN: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_n) |-> !$past(dq_oe)); // R4

    AST_PASS_USED_PRIME: assert property (@(posedge clk) disable iff (rst)
        (done && pass) |-> (prime_cnt != '0)); // R6

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones({pass, fail, reject}) == 1)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R9
endmodule

bind eprom_burner epb_checker #(.MAX_PRIME(MAX_PRIME), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy_o),
    .done      (done_o),
    .pass      (pass_o),
    .fail      (fail_o),
    .reject    (reject_o),
    .prime_cnt (prime_cnt_o),
    .hv        (hv_sel_o),
    .ce_n      (ce_n_o),
    .oe_n      (oe_n_o),
    .pgm_n     (pgm_n_o),
    .maddr     (maddr_o),
    .dq_oe     (mdq_oe_o)
);

// File: tb/eprom_burner_tb_top.sv
module eprom_burner_tb_top;
    localparam int DIV  = 4;
    localparam int MAXP = 15;
    localparam int MULT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        word_i = 1'b0;
    logic [12:0] addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        busy_o, done_o, pass_o, fail_o, reject_o, hv_sel_o;
    logic        ce_n_o, oe_n_o, pgm_n_o, mdq_oe_o;
    logic [3:0]  prime_cnt_o;
    logic [12:0] maddr_o;
    logic [7:0]  mdq_o;
    logic [7:0]  mdq_i = 8'hFF;

    always #10 clk = ~clk;

    eprom_burner #(.TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .word_i(word_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o),
        .pass_o(pass_o), .fail_o(fail_o), .reject_o(reject_o),
        .prime_cnt_o(prime_cnt_o), .hv_sel_o(hv_sel_o), .ce_n_o(ce_n_o),
        .oe_n_o(oe_n_o), .pgm_n_o(pgm_n_o), .maddr_o(maddr_o), .mdq_o(mdq_o),
        .mdq_oe_o(mdq_oe_o), .mdq_i(mdq_i)
    );

    typedef struct { int addr; int len; } pulse_t;
    typedef struct { logic pass; logic fail; logic reject; int cnt; logic rd_hv; } res_t;

    pulse_t     exp_p[$];
    res_t       exp_r[$];
    logic [7:0] mem  [int];
    int         pcnt [int];
    int         need [int];
    int         checks = 0;
    int         fails  = 0;
    bit         finished = 0;

    int         plen = 0;
    int         paddr = 0;
    logic [7:0] pdat = 8'h00;
    bit         pok = 1;
    logic       last_hv = 1'b0;

    function automatic logic [7:0] rd_mem(int a);
        return mem.exists(a) ? mem[a] : 8'hFF;
    endfunction
    function automatic int need_of(int a);
        return need.exists(a) ? need[a] : 1;
    endfunction
    function automatic int pc_of(int a);
        return pcnt.exists(a) ? pcnt[a] : 0;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // monitor: pulses, reads, completions and the memory model
    always @(negedge clk) begin
        if (!rst) begin
            if (!pgm_n_o) begin
                plen++;
                paddr = int'(maddr_o);
                pdat  = mdq_o;
                pok   = pok && hv_sel_o && mdq_oe_o && oe_n_o && !ce_n_o;
            end else if (plen > 0) begin
                if (exp_p.size() == 0) begin
                    check(0, "R9 unexpected strobe", paddr, 0);
                end else begin
                    pulse_t e;
                    e = exp_p.pop_front();
                    check(pok, "R3 strobe levels", int'(pok), 1);
                    check(e.addr == paddr, "R8 strobe address", paddr, e.addr);
                    check(e.len == plen, (e.len == DIV) ? "R3 prime length" : "R6 final length",
                          plen, e.len);
                end
                if (pok) begin
                    pcnt[paddr] = pc_of(paddr) + 1;
                    if (pcnt[paddr] >= need_of(paddr)) mem[paddr] = rd_mem(paddr) & pdat;
                end
                plen = 0;
                pok  = 1;
            end
            if (!oe_n_o) last_hv = hv_sel_o;
            if (done_o) begin
                if (exp_r.size() == 0) begin
                    check(0, "R9 unexpected done", 1, 0);
                end else begin
                    res_t e;
                    string rq;
                    e  = exp_r.pop_front();
                    rq = e.reject ? "R2 outcome" : (e.fail ? "R5 outcome" : "R7 outcome");
                    check({pass_o, fail_o, reject_o} == {e.pass, e.fail, e.reject}, rq,
                          int'({pass_o, fail_o, reject_o}), int'({e.pass, e.fail, e.reject}));
                    check(int'(prime_cnt_o) == e.cnt, "R6 prime count", int'(prime_cnt_o), e.cnt);
                    check(last_hv == e.rd_hv, "R7 last read supply", int'(last_hv), int'(e.rd_hv));
                end
            end
        end
        mdq_i = (!ce_n_o && !oe_n_o && !mdq_oe_o) ? rd_mem(int'(maddr_o)) : 8'hFF;
    end

    // driver: computes expected strobes and outcome, then issues the request
    task automatic run_req(int a, logic [15:0] d, bit word, int nh, int nl, bit poke);
        int   ad[2];
        logic [7:0] dv[2];
        int   nb;
        bit   rej;
        bit   failed;
        int   lastc;
        res_t r;
        nb = word ? 2 : 1;
        if (word) begin
            ad[0] = a & ~1; dv[0] = d[15:8]; need[ad[0]] = nh;
            ad[1] = a | 1;  dv[1] = d[7:0];  need[ad[1]] = nl;
        end else begin
            ad[0] = a; dv[0] = d[7:0]; need[ad[0]] = nh;
        end
        rej = 0;
        for (int i = 0; i < nb; i++) if ((~rd_mem(ad[i]) & dv[i]) != 8'h00) rej = 1;
        failed = 0;
        lastc  = 0;
        if (!rej) begin
            for (int i = 0; i < nb && !failed; i++) begin
                int k;
                if (rd_mem(ad[i]) == dv[i]) k = 1;
                else k = need_of(ad[i]) - pc_of(ad[i]);
                if (k < 1) k = 1;
                if (k > MAXP) begin
                    for (int j = 0; j < MAXP; j++) exp_p.push_back('{ad[i], DIV});
                    failed = 1;
                    lastc  = MAXP;
                end else begin
                    for (int j = 0; j < k; j++) exp_p.push_back('{ad[i], DIV});
                    exp_p.push_back('{ad[i], MULT * k * DIV});
                    lastc = k;
                end
            end
        end
        if (rej)         r = '{1'b0, 1'b0, 1'b1, 0, 1'b0};
        else if (failed) r = '{1'b0, 1'b1, 1'b0, lastc, 1'b1};
        else             r = '{1'b1, 1'b0, 1'b0, lastc, 1'b0};
        exp_r.push_back(r);

        @(negedge clk);
        start_i = 1'b1; addr_i = 13'(a); wdata_i = d; word_i = word;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R9 busy after start", int'(busy_o), 1);
        if (poke) begin
            repeat (6) @(negedge clk);
            start_i = 1'b1; addr_i = 13'h0060; wdata_i = 16'h0000; word_i = 1'b0;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        check(busy_o == 1'b0, "R9 busy low at done", int'(busy_o), 0);
        @(negedge clk);
        check(done_o == 1'b0, "R9 done one clock", int'(done_o), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(busy_o == 0 && done_o == 0, "R1 reset busy/done", int'({busy_o, done_o}), 0);
        check({ce_n_o, oe_n_o, pgm_n_o} == 3'b111, "R1 reset strobes",
              int'({ce_n_o, oe_n_o, pgm_n_o}), 7);
        check(mdq_oe_o == 0 && hv_sel_o == 0, "R1 reset bus/supply",
              int'({mdq_oe_o, hv_sel_o}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        run_req(32'h0010, 16'h00A5, 0, 3, 1, 0);   // R6 three primes
        run_req(32'h1FFF, 16'h0000, 0, 1, 1, 0);   // R3 single prime, top address
        run_req(32'h0020, 16'h003C, 0, 15, 1, 0);  // R5 boundary: pass on 15th
        run_req(32'h0030, 16'h0055, 0, 16, 1, 0);  // R5 fail after 15
        run_req(32'h0041, 16'h12F0, 1, 2, 4, 0);   // R8 word order
        run_req(32'h0010, 16'h005A, 0, 1, 1, 0);   // R2 reject
        check(rd_mem(32'h0010) == 8'hA5, "R2 memory untouched", int'(rd_mem(32'h0010)), 'hA5);
        run_req(32'h0010, 16'h00A5, 0, 1, 1, 0);   // R6 already equal, one prime
        run_req(32'h0050, 16'h000F, 0, 2, 1, 1);   // R9 start ignored while busy
        check(rd_mem(32'h0060) == 8'hFF, "R9 ignored start left memory", int'(rd_mem(32'h0060)), 'hFF);
        run_req(32'h0040, 16'h12FF, 1, 1, 1, 0);   // R2 word, low byte illegal
        check(rd_mem(32'h0040) == 8'h12, "R2 word high byte untouched", int'(rd_mem(32'h0040)), 'h12);
        run_req(32'h0070, 16'h8001, 1, 16, 1, 0);  // R5/R8 high byte fails, no low pulses
        check(rd_mem(32'h0071) == 8'hFF, "R8 low byte skipped", int'(rd_mem(32'h0071)), 'hFF);

        repeat (10) @(negedge clk);
        check(exp_p.size() == 0, "R3 missing strobes", exp_p.size(), 0);
        check(exp_r.size() == 0, "R9 missing completions", exp_r.size(), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule